// File: doc/BRIEF.md
# Four-Pair PWM Output Stage

This block turns one shared time-base count into eight pulse-width-modulated pins, grouped as four pairs (pins 0/1, 2/3, 4/5, 6/7). Each pair holds a duty word that is two bits wider than the count. The count is extended with two zero fraction bits and compared against the duty word. A pair can drive both of its pins with the same compare result (independent operation). It can also drive its even pin with the compare result and its odd pin with the inverse, with a programmable dead interval between the two (complementary operation). The time-base counter is external. It supplies the count and a one-cycle boundary pulse at the start of each period.

Behind the pair logic sit three more stages. A pin-enable decoder selects which pins carry PWM. A per-pin manual override replaces the PWM value with a fixed level. A polarity stage picks the active level separately for even and odd pins. Software reaches all settings through a simple write port: an address, data and a write strobe.

Each pair unit is a small state machine. Its states are:
- `P_IDLE`: held, both inactive.
- `P_INDEP`: both pins follow the registered compare.
- `P_EVEN_ON`: even pin active.
- `P_ODD_ON`: odd pin active.
- `P_DEAD_EVEN`: both pins inactive, waiting to turn the even pin on.
- `P_DEAD_ODD`: both pins inactive, waiting to turn the odd pin on.

Its transitions are:
- Any state goes to `P_IDLE` while neither pin of the pair is enabled.
- Any state goes to `P_INDEP` while the pair is in independent mode.
- `P_IDLE` or `P_INDEP` goes to a dead state, chosen by the compare result, when complementary mode starts.
- `P_EVEN_ON` goes to `P_DEAD_ODD` when the compare falls.
- `P_ODD_ON` goes to `P_DEAD_EVEN` when the compare rises.
- A dead state goes to its on state when its counter expires.
- A dead state goes to the opposite dead state, with the counter reloaded, if the compare reverses during the wait.
- With a dead-time of zero, every dead state is skipped.

Top module: `pwm_pair_stage`

## Requirements
- R1: After reset every pin drives 0. At reset: the enable code is 000, all duty words are 0, all override-control bits are 1, the override state is 0, override sync is off, all pairs are complementary, the dead-time is 0 and both polarity bits are 0.
- R2: Pair n's compare is true when {count, 2'b00} < duty word n. Duty word n is written at address n, for n from 0 to 3, with data bits [13:0]. A pin shows a count change one clock edge after the count is presented.
- R3: A duty word of 0 never makes a pin active. A duty word of at least 4 × (largest count + 1) keeps a pin active for every count up to that largest value.
- R4: Address 4, bit n, selects the mode of pair n: 1 is independent (both pins show the compare), 0 is complementary (even pin shows the compare, odd pin its inverse).
- R5: In complementary mode, once one pin of a pair turns inactive, both pins stay inactive for exactly DT clock cycles before the other pin turns active. DT is written at address 9 (8 bits). When DT is 0 the hand-over takes one edge.
- R6: Address 5 holds a 3-bit enable code, which sets the pins carrying PWM (given as a pin bit mask): 000→00, 001→02, 010→03, 011→0F, 100→3F, 101→FF, 110→0A, 111→AA.
- R7: A pin that is not enabled drives 0, whatever the override and polarity settings.
- R8: A pair with no enabled pin keeps its dead-time logic in reset. When the pair is enabled again in complementary mode, a full DT wait passes before its first active level.
- R9: Override-control (address 6) has one bit per pin: 1 means the pin follows the PWM, 0 means the pin takes the active level given by the same bit of override-state (address 7).
- R10: With override sync (address 8, bit 0) at 0, an override write shows on the pins right after the write edge.
- R11: With override sync at 1, override writes reach the pins only at an edge where the time-base boundary pulse is high.
- R12: Address 10 sets polarity. Bit 0 inverts the even pins and bit 1 inverts the odd pins; 0 means active-high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tb_count_i | input | 12 | Shared time-base count |
| tb_wrap_i | input | 1 | One-cycle pulse at the start of each period |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 14 | Register write data |
| pwm_out_o | output | 8 | PWM pins, bit i is pin i |

## Verification
A pair state machine stuck in the wrong state shows up on the pins within one clock edge. Both pins of a complementary pair would be active together, or the dead gap would be missing or miscounted. This is visible at the sample where the hand-over should end. A dead counter that is not reset when a pair is disabled shows as a short first gap after re-enabling. A stale override-sync register shows as the pins changing before the boundary pulse, or never changing at all.

// File: rtl/pwm_stage_pkg.sv
package pwm_stage_pkg;

    localparam int PAIRS = 4;
    localparam int PINS  = 2 * PAIRS;
    localparam int EN_W  = 3;
    localparam int POL_W = 2;

    // write address map
    localparam int A_MODE  = 4;
    localparam int A_EN    = 5;
    localparam int A_OVCTL = 6;
    localparam int A_OVSTA = 7;
    localparam int A_OSYNC = 8;
    localparam int A_DEAD  = 9;
    localparam int A_POL   = 10;

    typedef enum logic [2:0] {
        P_IDLE,
        P_INDEP,
        P_DEAD_EVEN,
        P_EVEN_ON,
        P_DEAD_ODD,
        P_ODD_ON
    } pair_state_t;

    // enable code to pin mask
    function automatic logic [PINS-1:0] pin_mask(input logic [EN_W-1:0] code);
        logic [PINS-1:0] m;
        unique case (code)
            3'b000:  m = 8'h00;
            3'b001:  m = 8'h02;
            3'b010:  m = 8'h03;
            3'b011:  m = 8'h0F;
            3'b100:  m = 8'h3F;
            3'b101:  m = 8'hFF;
            3'b110:  m = 8'h0A;
            default: m = 8'hAA;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
    import pwm_stage_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int FRAC_W = 2,
    parameter int DT_W   = 8,
    parameter int ADDR_W = 4
) (
    input  logic                                 clk_i,
    input  logic                                 rst_ni,
    input  logic                                 wr_en_i,
    input  logic [ADDR_W-1:0]                    wr_addr_i,
    input  logic [CNT_W+FRAC_W-1:0]              wr_data_i,
    input  logic                                 tb_wrap_i,
    output logic [PAIRS-1:0][CNT_W+FRAC_W-1:0]   duty_o,
    output logic [PAIRS-1:0]                     mode_o,
    output logic [EN_W-1:0]                      en_code_o,
    output logic [PINS-1:0]                      ovr_ctrl_o,
    output logic [PINS-1:0]                      ovr_state_o,
    output logic [DT_W-1:0]                      dt_o,
    output logic [POL_W-1:0]                     pol_o
);

    localparam int DUTY_W = CNT_W + FRAC_W;

    logic [PINS-1:0] ctl_sh_q, sta_sh_q;
    logic [PINS-1:0] ctl_sh_d, sta_sh_d;
    logic [PINS-1:0] ctl_eff_q, sta_eff_q;
    logic            osync_q;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
        return a == ADDR_W'(target);
    endfunction

    // one duty word per pair, address equals pair index
    for (genvar g = 0; g < PAIRS; g++) begin : g_duty
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                duty_o[g] <= '0;
            end else if (wr_en_i && hit(wr_addr_i, g)) begin
                duty_o[g] <= wr_data_i[DUTY_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mode_o    <= '0;
            en_code_o <= '0;
            dt_o      <= '0;
            pol_o     <= '0;
            osync_q   <= 1'b0;
        end else if (wr_en_i) begin
            if (hit(wr_addr_i, A_MODE))  mode_o    <= wr_data_i[PAIRS-1:0];
            if (hit(wr_addr_i, A_EN))    en_code_o <= wr_data_i[EN_W-1:0];
            if (hit(wr_addr_i, A_DEAD))  dt_o      <= wr_data_i[DT_W-1:0];
            if (hit(wr_addr_i, A_POL))   pol_o     <= wr_data_i[POL_W-1:0];
            if (hit(wr_addr_i, A_OSYNC)) osync_q   <= wr_data_i[0];
        end
    end

    // override shadow: value as written
    always_comb begin
        ctl_sh_d = ctl_sh_q;
        sta_sh_d = sta_sh_q;
        if (wr_en_i && hit(wr_addr_i, A_OVCTL)) ctl_sh_d = wr_data_i[PINS-1:0];
        if (wr_en_i && hit(wr_addr_i, A_OVSTA)) sta_sh_d = wr_data_i[PINS-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_sh_q <= '1;
            sta_sh_q <= '0;
        end else begin
            ctl_sh_q <= ctl_sh_d;
            sta_sh_q <= sta_sh_d;
        end
    end

    // effective override: immediate, or only on a time-base boundary
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_eff_q <= '1;
            sta_eff_q <= '0;
        end else if (!osync_q || tb_wrap_i) begin
            ctl_eff_q <= ctl_sh_d;
            sta_eff_q <= sta_sh_d;
        end
    end

    assign ovr_ctrl_o  = ctl_eff_q;
    assign ovr_state_o = sta_eff_q;

    // R11
    sync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (osync_q && !tb_wrap_i) |=> ($stable(sta_eff_q) && $stable(ctl_eff_q)));

endmodule

// File: rtl/pwm_pair_unit.sv
module pwm_pair_unit
    import pwm_stage_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int FRAC_W = 2,
    parameter int DT_W   = 8
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [CNT_W-1:0]        count_i,
    input  logic [CNT_W+FRAC_W-1:0] duty_i,
    input  logic                    indep_i,
    input  logic                    hold_i,
    input  logic [DT_W-1:0]         dt_i,
    output logic                    even_act_o,
    output logic                    odd_act_o
);

    localparam int DUTY_W = CNT_W + FRAC_W;

    pair_state_t     state_q, state_d;
    logic [DT_W-1:0] cnt_q, cnt_d;
    logic            ind_q;
    logic            cmp;
    logic            no_dead;
    pair_state_t     go_even, go_odd;
    logic [DT_W-1:0] dt_load;

    assign cmp     = {count_i, {FRAC_W{1'b0}}} < DUTY_W'(duty_i);
    assign no_dead = (dt_i == '0);
    assign go_even = no_dead ? P_EVEN_ON : P_DEAD_EVEN;
    assign go_odd  = no_dead ? P_ODD_ON  : P_DEAD_ODD;
    assign dt_load = dt_i - DT_W'(1);

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= P_IDLE;
            cnt_q   <= '0;
            ind_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ind_q   <= cmp && !hold_i;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (hold_i) begin
            state_d = P_IDLE;
            cnt_d   = '0;
        end else if (indep_i) begin
            state_d = P_INDEP;
        end else begin
            unique case (state_q)
                P_IDLE, P_INDEP: begin
                    state_d = cmp ? go_even : go_odd;
                    cnt_d   = dt_load;
                end
                P_EVEN_ON: begin
                    if (!cmp) begin
                        state_d = go_odd;
                        cnt_d   = dt_load;
                    end
                end
                P_ODD_ON: begin
                    if (cmp) begin
                        state_d = go_even;
                        cnt_d   = dt_load;
                    end
                end
                P_DEAD_EVEN: begin
                    if (!cmp) begin
                        state_d = go_odd;
                        cnt_d   = dt_load;
                    end else if (cnt_q == '0) begin
                        state_d = P_EVEN_ON;
                    end else begin
                        cnt_d = cnt_q - DT_W'(1);
                    end
                end
                P_DEAD_ODD: begin
                    if (cmp) begin
                        state_d = go_even;
                        cnt_d   = dt_load;
                    end else if (cnt_q == '0) begin
                        state_d = P_ODD_ON;
                    end else begin
                        cnt_d = cnt_q - DT_W'(1);
                    end
                end
                default: state_d = P_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        even_act_o = 1'b0;
        odd_act_o  = 1'b0;
        unique case (state_q)
            P_INDEP: begin
                even_act_o = ind_q;
                odd_act_o  = ind_q;
            end
            P_EVEN_ON: even_act_o = 1'b1;
            P_ODD_ON:  odd_act_o  = 1'b1;
            default: ;
        endcase
    end

    // R5
    dead_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == P_EVEN_ON && $past(state_q) != P_EVEN_ON && $past(dt_i) != '0)
        |-> $past(state_q) == P_DEAD_EVEN);

    // R5
    dead_odd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == P_ODD_ON && $past(state_q) != P_ODD_ON && $past(dt_i) != '0)
        |-> $past(state_q) == P_DEAD_ODD);

    // R4
    comp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != P_INDEP) |-> !(even_act_o && odd_act_o));

    // R3
    zero_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(duty_i == '0) |-> !ind_q);

endmodule

// File: rtl/pwm_pin_mux.sv
module pwm_pin_mux
    import pwm_stage_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [EN_W-1:0]   en_code_i,
    input  logic [PINS-1:0]   ovr_ctrl_i,
    input  logic [PINS-1:0]   ovr_state_i,
    input  logic [POL_W-1:0]  pol_i,
    input  logic [PINS-1:0]   act_i,
    output logic [PINS-1:0]   pin_en_o,
    output logic [PINS-1:0]   pwm_out_o
);

    assign pin_en_o = pin_mask(en_code_i);

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        logic level;
        assign level        = ovr_ctrl_i[i] ? act_i[i] : ovr_state_i[i];
        assign pwm_out_o[i] = pin_en_o[i] & (level ^ pol_i[i % 2]);
    end

    // R6
    en_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_code_i == '0) |-> (pwm_out_o == '0));

endmodule

// File: rtl/pwm_pair_stage.sv
module pwm_pair_stage
    import pwm_stage_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int FRAC_W = 2,
    parameter int DT_W   = 8,
    parameter int ADDR_W = 4
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [CNT_W-1:0]        tb_count_i,
    input  logic                    tb_wrap_i,
    input  logic                    wr_en_i,
    input  logic [ADDR_W-1:0]       wr_addr_i,
    input  logic [CNT_W+FRAC_W-1:0] wr_data_i,
    output logic [PINS-1:0]         pwm_out_o
);

    localparam int DUTY_W = CNT_W + FRAC_W;

    logic [PAIRS-1:0][DUTY_W-1:0] duty;
    logic [PAIRS-1:0]             mode;
    logic [EN_W-1:0]              en_code;
    logic [PINS-1:0]              ovr_ctrl, ovr_state;
    logic [DT_W-1:0]              dt;
    logic [POL_W-1:0]             pol;
    logic [PINS-1:0]              pin_en;
    logic [PINS-1:0]              act;

    pwm_cfg_regs #(
        .CNT_W  (CNT_W),
        .FRAC_W (FRAC_W),
        .DT_W   (DT_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .tb_wrap_i   (tb_wrap_i),
        .duty_o      (duty),
        .mode_o      (mode),
        .en_code_o   (en_code),
        .ovr_ctrl_o  (ovr_ctrl),
        .ovr_state_o (ovr_state),
        .dt_o        (dt),
        .pol_o       (pol)
    );

    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        logic hold;
        assign hold = !(pin_en[2*g] || pin_en[2*g+1]);

        pwm_pair_unit #(
            .CNT_W  (CNT_W),
            .FRAC_W (FRAC_W),
            .DT_W   (DT_W)
        ) u_pair (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .count_i    (tb_count_i),
            .duty_i     (duty[g]),
            .indep_i    (mode[g]),
            .hold_i     (hold),
            .dt_i       (dt),
            .even_act_o (act[2*g]),
            .odd_act_o  (act[2*g+1])
        );
    end

    pwm_pin_mux u_mux (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_code_i   (en_code),
        .ovr_ctrl_i  (ovr_ctrl),
        .ovr_state_i (ovr_state),
        .pol_i       (pol),
        .act_i       (act),
        .pin_en_o    (pin_en),
        .pwm_out_o   (pwm_out_o)
    );

endmodule

// File: tb/test_pwm_pair_stage.sv
module test_pwm_pair_stage;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] tb_count = '0;
    logic        tb_wrap = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [13:0] wr_data = '0;
    logic [7:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pwm_pair_stage i_pwm_pair_stage (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .tb_count_i (tb_count),
        .tb_wrap_i  (tb_wrap),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .pwm_out_o  (pwm_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a[3:0];
        wr_data = d[13:0];
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic logic [7:0] exp_mask(input int code);
        case (code)
            0: return 8'h00;
            1: return 8'h02;
            2: return 8'h03;
            3: return 8'h0F;
            4: return 8'h3F;
            5: return 8'hFF;
            6: return 8'h0A;
            default: return 8'hAA;
        endcase
    endfunction

    task automatic t_reset;
        chk("R1 reset pins", pwm_out, 8'h00);
    endtask

    task automatic t_indep;
        wr(4, 'hF);
        wr(5, 5);
        wr(0, 40);
        tb_count = 12'd9; step(2);
        chk("R2 count 9 below duty 40", pwm_out, 8'h03);
        tb_count = 12'd10; step(2);
        chk("R2 count 10 equals duty 40", pwm_out, 8'h00);
        wr(0, 41); step(1);
        chk("R2 fraction bits duty 41", pwm_out, 8'h03);
    endtask

    task automatic t_limits;
        wr(0, 0); tb_count = 12'd0; step(2);
        chk("R3 duty zero inactive", pwm_out, 8'h00);
        wr(0, 400); tb_count = 12'd99; step(2);
        chk("R3 duty 4x(period+1)", pwm_out, 8'h03);
        wr(0, 16383); tb_count = 12'd4095; step(2);
        chk("R3 max duty at max count", pwm_out, 8'h03);
    endtask

    task automatic t_comp;
        wr(9, 0);
        wr(4, 0);
        wr(0, 40);
        tb_count = 12'd5; step(3);
        chk("R4 complementary even on", pwm_out, 8'hA9);
        tb_count = 12'd20; step(3);
        chk("R4 complementary odd on", pwm_out, 8'hAA);
    endtask

    task automatic t_dead;
        wr(9, 3);
        tb_count = 12'd20; step(8);
        tb_count = 12'd5;
        for (int i = 1; i <= 4; i++) begin
            step(1);
            if (i == 3) chk("R5 dead gap to even cycle 3", {6'd0, pwm_out[1:0]}, 8'h00);
            if (i == 4) chk("R5 even on after 3 cycles", {6'd0, pwm_out[1:0]}, 8'h01);
        end
        tb_count = 12'd20;
        for (int i = 1; i <= 4; i++) begin
            step(1);
            if (i == 3) chk("R5 dead gap to odd cycle 3", {6'd0, pwm_out[1:0]}, 8'h00);
            if (i == 4) chk("R5 odd on after 3 cycles", {6'd0, pwm_out[1:0]}, 8'h02);
        end
    endtask

    task automatic t_reenable;
        for (int p = 0; p < 4; p++) wr(p, 16383);
        wr(5, 0); step(3);
        wr(5, 5);
        for (int i = 1; i <= 5; i++) begin
            if (i > 1) step(1);
            if (i == 4) chk("R8 fresh dead gap after enable", pwm_out, 8'h00);
            if (i == 5) chk("R8 even pins on after gap", pwm_out, 8'h55);
        end
    endtask

    task automatic t_enable;
        wr(4, 'hF);
        wr(9, 0);
        tb_count = 12'd0;
        for (int c = 0; c < 8; c++) begin
            wr(5, c); step(2);
            chk($sformatf("R6 enable code %0d", c), pwm_out, exp_mask(c));
        end
    endtask

    task automatic t_disabled;
        wr(5, 2); wr(6, 0); wr(7, 0); wr(10, 3); step(1);
        chk("R7 disabled pins low with inverted polarity", pwm_out, 8'h03);
        wr(10, 0); wr(7, 'hFF); step(1);
        chk("R7 disabled pins low with override active", pwm_out, 8'h03);
        wr(7, 0); wr(6, 'hFF);
    endtask

    task automatic t_override;
        wr(5, 5);
        for (int p = 0; p < 4; p++) wr(p, 0);
        wr(4, 'hF); step(2);
        wr(7, 'hA5);
        chk("R9 state ignored while control all ones", pwm_out, 8'h00);
        wr(6, 0);
        chk("R10 async override right after write", pwm_out, 8'hA5);
        wr(6, 'hF0);
        chk("R9 mixed override and PWM", pwm_out, 8'h05);
    endtask

    task automatic t_sync;
        wr(6, 0);
        wr(8, 1);
        wr(7, 'h3C); step(4);
        chk("R11 synced override waits for boundary", pwm_out, 8'hA5);
        tb_wrap = 1'b1; step(1); tb_wrap = 1'b0;
        chk("R11 synced override at boundary", pwm_out, 8'h3C);
    endtask

    task automatic t_polarity;
        wr(8, 0); wr(7, 0); step(1);
        wr(10, 1);
        chk("R12 even pins inverted", pwm_out, 8'h55);
        wr(10, 2);
        chk("R12 odd pins inverted", pwm_out, 8'hAA);
        wr(10, 0);
        chk("R12 active high", pwm_out, 8'h00);
    endtask

    initial begin
        step(3);
        t_reset();
        rst_n = 1'b1;
        step(2);
        chk("R1 pins low after reset release", pwm_out, 8'h00);
        t_indep();
        t_limits();
        t_comp();
        t_dead();
        t_reenable();
        t_enable();
        t_disabled();
        t_override();
        t_sync();
        t_polarity();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all R actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule